// File: doc/BRIEF.md
# GPIO Port Data Register Bank

This block holds the output data for one 32-pin general-purpose port and lets a bus master read back either what it wrote or what the pins carry. The 32 data bits sit in two 16-bit halves: a high half for pins 31 to 16 and a low half for pins 15 to 0. A per-pin direction vector comes from an external function-select controller. A pin marked as an output drives its stored bit. For a pin marked as an input, the drive value is held at zero and a read of the data half returns the synchronized pin level. Two further read-only halves always return the synchronized pin levels, whatever the direction.

The bus side is a plain strobe interface with no back-pressure. A write is taken on the rising clock edge where `wr_stb` is high. Read data is combinational and valid in the same cycle as `rd_stb`. No access ever stalls, so there is no ready signal. The bus is 32 bits wide and big-endian: byte offset 0 is lane `be[3]`, which is `wdata[31:24]` and `rdata[31:24]`. The data storage has its own reset domain. The power-on reset and deep standby clear it. The manual reset clears only the pin synchronizer.

Top module: `gpio_port_regs`

## Requirements
- R1: `pin_out[i]` equals the stored data bit i when `dir[i]`=1 (output), and is 0 when `dir[i]`=0 (input).
- R2: For a pin with `dir[i]`=1, a data-half read returns the stored bit regardless of `pin_in[i]`.
- R3: For a pin with `dir[i]`=0, a data-half read returns the synchronized level of `pin_in[i]`, not the stored bit.
- R4: A write to the data bit of an input pin is stored. It does not appear on `pin_out` while the pin is an input, and it is read back and driven once `dir[i]` becomes 1.
- R5: The port halves are selected by `addr[2]`=1 (offset 4 is the high half, offset 6 is the low half). A read of them returns the synchronized pin levels for every pin, whatever `dir` holds.
- R6: Writes with `addr[2]`=1 change no stored data.
- R7: The data halves are selected by `addr[2]`=0 (offset 0 is the high half in `wdata[31:16]`, offset 2 is the low half in `wdata[15:0]`). Only the byte lanes with a set `be` bit are updated. Lane `be[3]` covers bits 31:24 and lane `be[0]` covers bits 7:0.
- R8: Only these (`addr[1:0]`, `be`) pairs are legal: (0,1000), (0,1100), (0,1111), (1,0100), (2,0010), (2,0011), (3,0001). A 32-bit access is therefore possible only at offsets 0 and 4. An illegal write changes nothing, and an illegal read returns 0.
- R9: A low `por_n` clears all stored data and the synchronizer at once (asynchronous reset).
- R10: Every clock edge with `deep_stby`=1 clears the stored data, and any write in that cycle is dropped.
- R11: A low `mrst_n` leaves the stored data unchanged, while the pin synchronizer is held at 0.
- R12: A change on `pin_in` shows in read data after exactly two rising clock edges.
- R13: `rdata` is 0 when `rd_stb` is low, and the byte lanes without a set `be` bit are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears data and synchronizer |
| mrst_n | input | 1 | Manual reset, active low, asynchronous; clears only the synchronizer |
| deep_stby | input | 1 | Deep standby entry; clears the data synchronously |
| addr | input | 3 | Byte offset of the access |
| be | input | 4 | Byte enables, `be[3]` = offset 0 |
| wdata | input | 32 | Write data, big-endian lanes |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| rdata | output | 32 | Read data, combinational |
| dir | input | 32 | Per-pin direction, 1 = output |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Pin drive values |

## Verification
The direction masks used are all-output, split high/low, and random per bit. They are applied while the pin levels differ from the stored bits, so each read shows per bit whether the latch or the pin was chosen. Every byte-enable shape is driven at each offset, the illegal ones included, which separates correct lane steering from accesses that must be dropped. Pin levels are changed under a held read, which exposes the synchronizer latency edge by edge. The manual reset, deep standby and power-on reset pulses are applied on top of stored data, which separates the two reset domains.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic {
    REG_DATA = 1'b0,
    REG_PINS = 1'b1
  } reg_kind_e;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_port_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFS_W = $clog2(LANES),
  localparam int AW = OFS_W + 1
) (
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] be,
  output logic             legal,
  output reg_kind_e        kind,
  output logic [LANES-1:0] lane_mask
);
  logic [OFS_W-1:0] ofs;
  logic [LANES-1:0] shape;
  int cnt;
  int ofs_i;

  assign ofs  = addr[OFS_W-1:0];
  assign kind = reg_kind_e'(addr[AW-1]);

  // An access is legal when it is naturally aligned, power-of-two sized,
  // and its enabled lanes start at the lane that the offset names.
  always_comb begin
    cnt = 0;
    for (int i = 0; i < LANES; i++) cnt = cnt + int'(be[i]);
    ofs_i = int'(ofs);
    shape = '0;
    legal = 1'b0;
    if (cnt != 0 && (cnt & (cnt - 1)) == 0 && (ofs_i & (cnt - 1)) == 0 &&
        ofs_i + cnt <= LANES) begin
      for (int i = 0; i < LANES; i++)
        shape[i] = (i >= LANES - ofs_i - cnt) && (i < LANES - ofs_i);
      legal = (shape == be);
    end
  end

  assign lane_mask = legal ? be : '0;
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[k] <= '0;
        else if (k == 0) stg[k] <= d;
        else stg[k] <= stg[(k == 0) ? 0 : k - 1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_data_latch.sv
module gpio_data_latch #(
  parameter int LANES = 4,
  localparam int W = LANES * 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clr,
  input  logic [LANES-1:0] we,
  input  logic [W-1:0]     wd,
  output logic [W-1:0]     q
);
  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q[l*8 +: 8] <= '0;
        else if (clr) q[l*8 +: 8] <= '0;
        else if (we[l]) q[l*8 +: 8] <= wd[l*8 +: 8];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int PIN_W = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LANES = PIN_W / 8,
  localparam int AW = $clog2(LANES) + 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             mrst_n,
  input  logic             deep_stby,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] be,
  input  logic [PIN_W-1:0] wdata,
  input  logic             wr_stb,
  input  logic             rd_stb,
  output logic [PIN_W-1:0] rdata,
  input  logic [PIN_W-1:0] dir,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] pin_out
);
  logic             acc_legal;
  reg_kind_e        acc_kind;
  logic [LANES-1:0] acc_mask;
  logic [LANES-1:0] data_we;
  logic [PIN_W-1:0] data_q;
  logic [PIN_W-1:0] sync_q;
  logic [PIN_W-1:0] mixed;
  logic [PIN_W-1:0] word;
  logic             sync_rst_n;

  gpio_bus_decode #(.LANES(LANES)) u_dec (
    .addr(addr), .be(be), .legal(acc_legal), .kind(acc_kind), .lane_mask(acc_mask)
  );

  // The synchronizer is in the manual-reset domain; the data storage is not.
  assign sync_rst_n = por_n & mrst_n;

  gpio_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(sync_rst_n), .d(pin_in), .q(sync_q)
  );

  assign data_we = (wr_stb && acc_kind == REG_DATA) ? acc_mask : '0;

  gpio_data_latch #(.LANES(LANES)) u_lat (
    .clk(clk), .por_n(por_n), .clr(deep_stby), .we(data_we), .wd(wdata), .q(data_q)
  );

  assign mixed   = (dir & data_q) | (~dir & sync_q);
  assign word    = (acc_kind == REG_DATA) ? mixed : sync_q;
  assign pin_out = data_q & dir;

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_rd
      assign rdata[l*8 +: 8] = (rd_stb && acc_mask[l]) ? word[l*8 +: 8] : 8'h00;
    end
  endgenerate
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int PIN_W = 32,
  localparam int LANES = PIN_W / 8,
  localparam int AW = $clog2(LANES) + 1
) (
  input logic             clk,
  input logic             por_n,
  input logic             mrst_n,
  input logic             deep_stby,
  input logic [AW-1:0]    addr,
  input logic [LANES-1:0] be,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic [PIN_W-1:0] rdata,
  input logic [PIN_W-1:0] dir,
  input logic [PIN_W-1:0] pin_out,
  input logic [PIN_W-1:0] data_q,
  input logic [PIN_W-1:0] sync_q
);
  p_pinout_gate_r1: assert property (@(posedge clk) disable iff (!por_n)
    (pin_out & ~dir) == '0);

  p_port_read_r5: assert property (@(posedge clk) disable iff (!por_n)
    (rd_stb && addr == {1'b1, {(AW-1){1'b0}}} && be == '1) |-> rdata == sync_q);

  p_port_write_ignored_r6: assert property (@(posedge clk) disable iff (!por_n)
    (wr_stb && addr[AW-1] && !deep_stby) |=> data_q == $past(data_q));

  p_dstby_clear_r10: assert property (@(posedge clk) disable iff (!por_n)
    deep_stby |=> data_q == '0);

  p_mrst_keep_r11: assert property (@(posedge clk) disable iff (!por_n)
    (!mrst_n && !deep_stby && !wr_stb) |=> data_q == $past(data_q));

  p_idle_rdata_r13: assert property (@(posedge clk) disable iff (!por_n)
    !rd_stb |-> rdata == '0);
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.PIN_W(PIN_W)) u_chk (
  .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .deep_stby(deep_stby),
  .addr(addr), .be(be), .wr_stb(wr_stb), .rd_stb(rd_stb), .rdata(rdata),
  .dir(dir), .pin_out(pin_out), .data_q(data_q), .sync_q(sync_q)
);

// File: tb/gpio_port_regs_tb_top.sv
`timescale 1ns/1ps
module gpio_port_regs_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, mrst_n = 1'b1, deep_stby = 1'b0;
  logic [2:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0, dir = '0, pin_in = '0;
  logic        wr_stb = 1'b0, rd_stb = 1'b0;
  logic [31:0] rdata, pin_out;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R9";

  always #4 clk = ~clk;

  gpio_port_regs dut_i (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .deep_stby(deep_stby),
    .addr(addr), .be(be), .wdata(wdata), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .rdata(rdata), .dir(dir), .pin_in(pin_in), .pin_out(pin_out)
  );

  // Reference model
  logic [31:0] m_lat = '0;
  logic [31:0] pq[$] = '{32'h0, 32'h0};

  function automatic bit m_legal(logic [1:0] o, logic [3:0] b);
    case ({o, b})
      {2'd0, 4'b1000}, {2'd0, 4'b1100}, {2'd0, 4'b1111}, {2'd1, 4'b0100},
      {2'd2, 4'b0010}, {2'd2, 4'b0011}, {2'd3, 4'b0001}: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] lanes(logic [3:0] b);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++) if (b[i]) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) m_lat = '0;
    else if (deep_stby) m_lat = '0;
    else if (wr_stb && !addr[2] && m_legal(addr[1:0], be))
      m_lat = (m_lat & ~lanes(be)) | (wdata & lanes(be));
  end

  always @(posedge clk or negedge por_n or negedge mrst_n) begin
    if (!por_n || !mrst_n) pq = '{32'h0, 32'h0};
    else begin pq.push_back(pin_in); void'(pq.pop_front()); end
  end

  function automatic logic [31:0] m_rdata();
    logic [31:0] syn = pq[0];
    logic [31:0] w;
    if (!rd_stb || !m_legal(addr[1:0], be)) return '0;
    w = addr[2] ? syn : ((dir & m_lat) | (~dir & syn));
    return w & lanes(be);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(cur_req, "model rdata", rdata, m_rdata());
    chk(cur_req, "model pin_out", pin_out, m_lat & dir);
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [2:0] a, logic [3:0] b, logic [31:0] d);
    addr = a; be = b; wdata = d; wr_stb = 1'b1; cyc(); wr_stb = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [3:0] b, logic [31:0] exp);
    addr = a; be = b; rd_stb = 1'b1; #2;
    chk(req, "read", rdata, exp);
    cyc(); rd_stb = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1; n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] bes [10] = '{4'b1000, 4'b1100, 4'b1111, 4'b0100, 4'b0010,
                             4'b0011, 4'b0001, 4'b0110, 4'b1110, 4'b0000};
    cyc(3); #1 por_n = 1'b1; cyc();
    dir = '1;
    cur_req = "R9";
    rd_chk("R9", 3'd0, 4'hF, 32'h0);
    chk("R9", "pin_out after reset", pin_out, 32'h0);

    cur_req = "R7";
    wr(3'd0, 4'hF, 32'h12345678);
    chk("R1", "pin_out word", pin_out, 32'h12345678);
    rd_chk("R2", 3'd0, 4'hF, 32'h12345678);
    wr(3'd1, 4'b0100, 32'h00AB0000);
    wr(3'd2, 4'b0011, 32'h0000CDEF);
    rd_chk("R7", 3'd0, 4'hF, 32'h12ABCDEF);
    rd_chk("R13", 3'd3, 4'b0001, 32'h000000EF);
    rd_chk("R7", 3'd0, 4'b1000, 32'h12000000);

    cur_req = "R3";
    dir = 32'hFFFF0000; pin_in = 32'hA5A5A5A5; cyc(3);
    rd_chk("R3", 3'd0, 4'hF, 32'h12ABA5A5);
    chk("R1", "pin_out split", pin_out, 32'h12AB0000);

    cur_req = "R4";
    wr(3'd2, 4'b0011, 32'h00001111);
    chk("R4", "pin_out input half", pin_out, 32'h12AB0000);
    rd_chk("R4", 3'd2, 4'b0011, 32'h0000A5A5);
    dir = '1; cyc();
    rd_chk("R4", 3'd0, 4'hF, 32'h12AB1111);

    cur_req = "R6";
    rd_chk("R5", 3'd4, 4'hF, 32'hA5A5A5A5);
    rd_chk("R5", 3'd6, 4'b0011, 32'h0000A5A5);
    wr(3'd4, 4'hF, 32'hFFFFFFFF);
    wr(3'd6, 4'b0011, 32'h0000FFFF);
    rd_chk("R6", 3'd0, 4'hF, 32'h12AB1111);

    cur_req = "R8";
    wr(3'd2, 4'hF, 32'h0);
    wr(3'd0, 4'b0110, 32'h0);
    wr(3'd1, 4'b1100, 32'h0);
    rd_chk("R8", 3'd0, 4'hF, 32'h12AB1111);
    rd_chk("R8", 3'd1, 4'b1000, 32'h0);
    rd_chk("R8", 3'd2, 4'hF, 32'h0);

    cur_req = "R12";
    addr = 3'd4; be = 4'hF; rd_stb = 1'b1; pin_in = 32'h0F0F0F0F; #2;
    chk("R12", "0 edges", rdata, 32'hA5A5A5A5);
    cyc(); #2 chk("R12", "1 edge", rdata, 32'hA5A5A5A5);
    cyc(); #2 chk("R12", "2 edges", rdata, 32'h0F0F0F0F);
    cyc(); rd_stb = 1'b0;

    cur_req = "R11";
    mrst_n = 1'b0; cyc();
    rd_chk("R11", 3'd0, 4'hF, 32'h12AB1111);
    rd_chk("R11", 3'd4, 4'hF, 32'h0);
    mrst_n = 1'b1; cyc(3);
    rd_chk("R11", 3'd4, 4'hF, 32'h0F0F0F0F);

    cur_req = "R10";
    deep_stby = 1'b1;
    wr(3'd0, 4'hF, 32'hFFFFFFFF);
    chk("R10", "pin_out in standby", pin_out, 32'h0);
    deep_stby = 1'b0;
    rd_chk("R10", 3'd0, 4'hF, 32'h0);
    wr(3'd0, 4'hF, 32'h55AA55AA);
    rd_chk("R10", 3'd0, 4'hF, 32'h55AA55AA);

    cur_req = "R9";
    por_n = 1'b0; #1;
    chk("R9", "async clear", pin_out, 32'h0);
    cyc(); por_n = 1'b1; cyc();

    cur_req = "R7";
    for (int i = 0; i < 400; i++) begin
      addr = 3'($urandom); be = bes[$urandom_range(9)]; wdata = $urandom;
      wr_stb = 1'($urandom); rd_stb = 1'($urandom);
      dir = $urandom; pin_in = $urandom;
      deep_stby = ($urandom_range(31) == 0);
      mrst_n = ($urandom_range(31) != 0);
      cyc();
    end
    wr_stb = 1'b0; rd_stb = 1'b0; deep_stby = 1'b0; mrst_n = 1'b1; cyc(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule